// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block is a direct-mapped instruction cache placed between a processor fetch port and a read-only external bus port. Each line holds several words. Every word has its own valid bit, so a line can be filled one word at a time. Each line also carries a tag and a lock bit. A byte-wide configuration write sets three things: the enable, a walking invalidation of the whole array (flush), and a release of every lock.

A fetch may be cached only when the cache is enabled, its address lies at or above the external-space base, and the fetch is not flagged as targeting a non-cacheable chip-select area. A chip-select area flagged this way pays one extra cycle over the path taken with the cache off. Any address below the external base goes straight to the bus. A line can be pinned by raising the lock input with the fetch that fills it. A pinned line keeps its tag, but it still accepts words that are missing under its own tag. The cache does not observe writes made to memory by other agents. Software restores coherence by flushing.

Top module: `icache_lock_top`

## Requirements
- R1: After reset the cache is disabled and every line is invalid and unlocked. `fetch_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: Configuration bits: bit 0 enables the cache, bit 1 flushes, bit 2 releases all locks. Writing 0x07 flushes, unlocks and enables in one write, and caching then starts.
- R3: A write with bit 1 set clears one line per cycle. `fetch_ready` stays 0 for LINES+1 cycles after the write: one pending cycle, then one cycle per line.
- R4: A hit drives `resp_valid` with the stored word in the cycle after acceptance. It issues no bus read and leaves the line unchanged.
- R5: Address fields: word select is addr[3:2], line index is addr[9:4], tag is addr[31:10]. A miss on an unlocked line whose tag differs reads the bus. It returns the bus word, then rewrites the tag and keeps only the fetched word valid.
- R6: A miss on a word that is invalid under a matching tag fills only that word. The other valid words of the line stay valid.
- R7: A tag miss on a locked line returns the bus word and leaves the line's tag and words intact.
- R8: A miss on an invalid word under the tag of a locked line fills that word and marks it valid.
- R9: When `fetch_lock` is 1 with a fetch that fills a line, that line becomes locked.
- R10: Fetches below EXT_BASE are never cached. Their latency equals the cache-off latency.
- R11: With the cache enabled, a fetch flagged non-cacheable is never cached and takes exactly one cycle more than the same fetch with the cache off.
- R12: When memory changes behind the cache, cached words keep returning old data until a flush. After the flush, fetches return the new data.
- R13: A write with bit 2 set and bit 1 clear clears every lock at once. It keeps the valid words and does not stall the fetch port.
- R14: With the cache disabled, every fetch reads the bus and nothing is cached. The response comes in the cycle after `mem_ack`, carrying `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: bit 0 enable, bit 1 flush, bit 2 unlock all |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | ADDR_W | Fetch byte address, word aligned |
| fetch_uncached_area | input | 1 | Fetch targets a chip-select area marked non-cacheable |
| fetch_lock | input | 1 | Lock the line filled by this fetch |
| fetch_ready | output | 1 | Fetch port can accept a request |
| resp_valid | output | 1 | Instruction word valid, one-cycle pulse |
| resp_data | output | DATA_W | Instruction word |
| mem_req | output | 1 | Bus read request, held until acknowledged |
| mem_addr | output | ADDR_W | Bus read address |
| mem_ack | input | 1 | Bus read done, one-cycle pulse |
| mem_rdata | input | DATA_W | Bus read data, valid with `mem_ack` |

## Verification
Faults in the valid, tag or lock state do not show up as wrong data on the first access. They show up as a latency that differs from the expected one: a one-cycle hit where a four-cycle bus read was due, or the reverse. They also show up as a change in the count of bus reads, on the very next fetch to the affected line. For this reason every fetch checks latency, bus-read count and returned word together. A scoreboard queue pairs each accepted fetch with its word, so a spurious or missing response appears at the next response edge. Stale data after a memory change tells whether the cache truly held the word. The length of the not-ready window tells whether the flush walks every line.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int CFG_EN     = 0;
    localparam int CFG_FLUSH  = 1;
    localparam int CFG_UNLOCK = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_BUS, ST_FLUSH} fsm_e;
    typedef enum logic [1:0] {FILL_NONE, FILL_WORD, FILL_LINE} fill_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
    import icache_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 22,
    parameter int WORDS = 4,
    localparam int SEL_W = $clog2(WORDS),
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [SEL_W-1:0] rd_sel,
    output logic             rd_tag_eq,
    output logic             rd_word_vld,
    output logic             rd_any_vld,
    output logic             rd_locked,
    input  logic             wr_en,
    input  fill_e            wr_mode,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_lock,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             unlock_all
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic [LINES-1:0] lock_q;
    logic [WORDS-1:0] wr_onehot;

    assign wr_onehot   = WORDS'(1) << wr_sel;
    assign rd_tag_eq   = (tag_q[rd_idx] == rd_tag);
    assign rd_word_vld = vld_q[rd_idx][rd_sel];
    assign rd_any_vld  = |vld_q[rd_idx];
    assign rd_locked   = lock_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
            lock_q <= '0;
        end else begin
            if (unlock_all) lock_q <= '0;
            if (clr_en) vld_q[clr_idx] <= '0;
            if (wr_en) begin
                if (wr_mode == FILL_LINE) vld_q[wr_idx] <= wr_onehot;
                else                      vld_q[wr_idx] <= vld_q[wr_idx] | wr_onehot;
                if (wr_lock) lock_q[wr_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_mode == FILL_LINE) tag_q[wr_idx] <= wr_tag;
    end
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int IDX_W  = 6,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(WORDS),
    localparam int DEPTH = (1 << IDX_W) * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] word_q [DEPTH];

    assign rd_data = word_q[{rd_idx, rd_sel}];

    always_ff @(posedge clk) begin
        if (wr_en) word_q[{wr_idx, wr_sel}] <= wr_data;
    end
endmodule

// File: rtl/icache_lock_top.sv
module icache_lock_top
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int WORDS  = 4,
    parameter logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0010_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_uncached_area,
    input  logic              fetch_lock,
    output logic              fetch_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int SEL_W  = $clog2(WORDS);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - SEL_W - BYTE_W;
    localparam int LINES  = 1 << IDX_W;

    typedef struct packed {
        fsm_e              st;
        logic              en;
        logic              flush_pend;
        logic [IDX_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        fill_e             fill;
        logic              lock;
        logic              rv;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t s_d, s_q;

    // lookup side (request address) and fill side (held address)
    logic [SEL_W-1:0]  rq_sel, hd_sel;
    logic [IDX_W-1:0]  rq_idx, hd_idx;
    logic [TAG_W-1:0]  rq_tag, hd_tag;
    logic              tag_eq, word_vld, any_vld, locked;
    logic [DATA_W-1:0] hit_data;
    logic              wr_en, clr_en, unlock_all;
    logic              in_ext, cacheable;

    assign rq_sel = fetch_addr[BYTE_W +: SEL_W];
    assign rq_idx = fetch_addr[BYTE_W + SEL_W +: IDX_W];
    assign rq_tag = fetch_addr[ADDR_W-1 -: TAG_W];
    assign hd_sel = s_q.addr[BYTE_W +: SEL_W];
    assign hd_idx = s_q.addr[BYTE_W + SEL_W +: IDX_W];
    assign hd_tag = s_q.addr[ADDR_W-1 -: TAG_W];

    icache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORDS(WORDS)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rq_idx),
        .rd_tag     (rq_tag),
        .rd_sel     (rq_sel),
        .rd_tag_eq  (tag_eq),
        .rd_word_vld(word_vld),
        .rd_any_vld (any_vld),
        .rd_locked  (locked),
        .wr_en      (wr_en),
        .wr_mode    (s_q.fill),
        .wr_idx     (hd_idx),
        .wr_tag     (hd_tag),
        .wr_sel     (hd_sel),
        .wr_lock    (s_q.lock),
        .clr_en     (clr_en),
        .clr_idx    (s_q.cnt),
        .unlock_all (unlock_all)
    );

    icache_data_store #(.IDX_W(IDX_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .rd_idx (rq_idx),
        .rd_sel (rq_sel),
        .rd_data(hit_data),
        .wr_en  (wr_en),
        .wr_idx (hd_idx),
        .wr_sel (hd_sel),
        .wr_data(mem_rdata)
    );

    assign in_ext    = (fetch_addr >= EXT_BASE);
    assign cacheable = s_q.en && in_ext && !fetch_uncached_area;

    always_comb begin
        s_d         = s_q;
        s_d.rv      = 1'b0;
        fetch_ready = (s_q.st == ST_IDLE) && !s_q.flush_pend;
        mem_req     = (s_q.st == ST_BUS);
        mem_addr    = s_q.addr;
        wr_en       = 1'b0;
        clr_en      = 1'b0;
        unlock_all  = cfg_we && cfg_wdata[CFG_UNLOCK];

        case (s_q.st)
            ST_IDLE: begin
                if (s_q.flush_pend) begin
                    s_d.st         = ST_FLUSH;
                    s_d.cnt        = '0;
                    s_d.flush_pend = 1'b0;
                end else if (fetch_valid) begin
                    s_d.addr = fetch_addr;
                    s_d.lock = fetch_lock;
                    s_d.fill = FILL_NONE;
                    if (cacheable && tag_eq && word_vld) begin
                        s_d.rv    = 1'b1;
                        s_d.rdata = hit_data;
                    end else if (cacheable) begin
                        s_d.st = ST_BUS;
                        if (locked)
                            s_d.fill = tag_eq ? FILL_WORD : FILL_NONE;
                        else
                            s_d.fill = (tag_eq && any_vld) ? FILL_WORD : FILL_LINE;
                    end else if (s_q.en && in_ext) begin
                        s_d.st = ST_GAP;
                    end else begin
                        s_d.st = ST_BUS;
                    end
                end
            end
            ST_GAP: s_d.st = ST_BUS;
            ST_BUS: begin
                if (mem_ack) begin
                    s_d.rv    = 1'b1;
                    s_d.rdata = mem_rdata;
                    s_d.st    = ST_IDLE;
                    wr_en     = (s_q.fill != FILL_NONE);
                end
            end
            ST_FLUSH: begin
                clr_en  = 1'b1;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == IDX_W'(LINES - 1)) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (cfg_we) begin
            s_d.en = cfg_wdata[CFG_EN];
            if (cfg_wdata[CFG_FLUSH]) s_d.flush_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign resp_valid = s_q.rv;
    assign resp_data  = s_q.rdata;
endmodule

// File: rtl/icache_lock_chk.sv
module icache_lock_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0010_0000)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_uncached_area,
    input logic              fetch_ready,
    input logic              resp_valid,
    input logic [DATA_W-1:0] resp_data,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata
);
    a_r3_flush_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[1] |=> !fetch_ready);

    a_r5_bus_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    a_r4_no_accept_during_bus: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_ready);

    a_r10_low_space_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_ready && (fetch_addr < EXT_BASE) |=> !resp_valid);

    a_r11_uncached_area_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_ready && fetch_uncached_area |=> !resp_valid);

    a_r14_ack_gives_response: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> resp_valid && resp_data == $past(mem_rdata));
endmodule

bind icache_lock_top icache_lock_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_BASE(EXT_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_uncached_area(fetch_uncached_area), .fetch_ready(fetch_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/tb_icache_lock_top.sv
`timescale 1ns/1ps
module tb_icache_lock_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LINES  = 64;
    localparam logic [31:0] EXT = 32'h0010_0000;
    localparam int HIT_LAT = 1;
    localparam int BUS_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_uncached_area = 1'b0;
    logic        fetch_lock = 1'b0;
    logic        fetch_ready, resp_valid, mem_req;
    logic [31:0] resp_data, mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int bus_reads = 0;
    int wcnt = 0;
    logic [31:0] gen = 32'h0;
    logic [31:0] exp_q [$];
    string       lbl_q [$];

    icache_lock_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(6), .WORDS(4),
                      .EXT_BASE(EXT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_uncached_area(fetch_uncached_area), .fetch_lock(fetch_lock),
        .fetch_ready(fetch_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] g);
        return (a * 32'h9E37_79B1) ^ g;
    endfunction

    // bus memory: acknowledges on the second edge that sees a request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (wcnt == 1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_word(mem_addr, gen);
                wcnt      <= 0;
                bus_reads = bus_reads + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // monitor: pops the scoreboard on every response
    always @(negedge clk) begin : monitor
        logic [31:0] e;
        string       l;
        if (rst_n && resp_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4 spurious response: actual %h expected none", resp_data);
            end else begin
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                if (resp_data !== e) begin
                    n_bad++;
                    $display("FAIL %s data: actual %h expected %h", l, resp_data, e);
                end
            end
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input bit unc, input bit lk,
                         input logic [31:0] exp_data, input int exp_lat,
                         input int exp_reads, input string rq);
        int lat;
        int r0;
        @(negedge clk);
        fetch_addr = a;
        fetch_uncached_area = unc;
        fetch_lock = lk;
        fetch_valid = 1'b1;
        while (!fetch_ready) @(negedge clk);
        exp_q.push_back(exp_data);
        lbl_q.push_back(rq);
        r0 = bus_reads;
        @(negedge clk);
        fetch_valid = 1'b0;
        fetch_lock = 1'b0;
        fetch_uncached_area = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk(rq, "latency", lat, exp_lat);
        chk(rq, "bus reads", bus_reads - r0, exp_reads);
    endtask

    task automatic cfg(input logic [7:0] v, input int exp_stall, input string rq);
        int stall;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        stall = 0;
        while (!fetch_ready && stall < 1000) begin
            stall++;
            @(negedge clk);
        end
        chk(rq, "not-ready cycles", stall, exp_stall);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] a, b, c, d, lo, un;
        logic [31:0] old_g;
        a  = EXT + 32'h20;      // index 2, word 0
        b  = a + 32'h400;       // index 2, other tag
        c  = EXT + 32'h50;      // index 5, word 0
        d  = c + 32'h400;       // index 5, other tag
        lo = 32'h0000_2000;     // below external base
        un = EXT + 32'h70;      // used with non-cacheable area flag

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "fetch_ready", int'(fetch_ready), 1);
        chk("R1", "resp_valid", int'(resp_valid), 0);
        chk("R1", "mem_req", int'(mem_req), 0);

        // cache off after reset: nothing cached
        fetch(a, 0, 0, mem_word(a, gen), BUS_LAT, 1, "R1");
        fetch(a, 0, 0, mem_word(a, gen), BUS_LAT, 1, "R14");

        // flush + unlock + enable in one write
        cfg(8'h07, LINES + 1, "R3");
        fetch(a, 0, 0, mem_word(a, gen), BUS_LAT, 1, "R5");
        fetch(a, 0, 0, mem_word(a, gen), HIT_LAT, 0, "R2");
        fetch(a, 0, 0, mem_word(a, gen), HIT_LAT, 0, "R4");

        // word fill under matching tag
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), BUS_LAT, 1, "R6");
        fetch(a, 0, 0, mem_word(a, gen), HIT_LAT, 0, "R6");
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), HIT_LAT, 0, "R6");

        // conflicting tag replaces unlocked line
        fetch(b, 0, 0, mem_word(b, gen), BUS_LAT, 1, "R5");
        fetch(b, 0, 0, mem_word(b, gen), HIT_LAT, 0, "R5");
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), BUS_LAT, 1, "R5");

        // locking
        fetch(c, 0, 1, mem_word(c, gen), BUS_LAT, 1, "R9");
        fetch(d, 0, 0, mem_word(d, gen), BUS_LAT, 1, "R7");
        fetch(c, 0, 0, mem_word(c, gen), HIT_LAT, 0, "R9");
        fetch(d, 0, 0, mem_word(d, gen), BUS_LAT, 1, "R7");
        fetch(c + 8, 0, 0, mem_word(c + 8, gen), BUS_LAT, 1, "R8");
        fetch(c + 8, 0, 0, mem_word(c + 8, gen), HIT_LAT, 0, "R8");

        // unlock without flush
        cfg(8'h05, 0, "R13");
        fetch(c, 0, 0, mem_word(c, gen), HIT_LAT, 0, "R13");
        fetch(d, 0, 0, mem_word(d, gen), BUS_LAT, 1, "R13");
        fetch(d, 0, 0, mem_word(d, gen), HIT_LAT, 0, "R13");

        // low space and non-cacheable area
        fetch(lo, 0, 0, mem_word(lo, gen), BUS_LAT, 1, "R10");
        fetch(lo, 0, 0, mem_word(lo, gen), BUS_LAT, 1, "R10");
        fetch(un, 1, 0, mem_word(un, gen), BUS_LAT + 1, 1, "R11");
        fetch(un, 1, 0, mem_word(un, gen), BUS_LAT + 1, 1, "R11");

        // memory changes behind the cache
        old_g = gen;
        gen = 32'h5A5A_1234;
        fetch(a + 4, 0, 0, mem_word(a + 4, old_g), HIT_LAT, 0, "R12");
        cfg(8'h07, LINES + 1, "R2");
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), BUS_LAT, 1, "R12");
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), HIT_LAT, 0, "R12");

        // disable
        cfg(8'h00, 0, "R14");
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), BUS_LAT, 1, "R14");
        fetch(a + 4, 0, 0, mem_word(a + 4, gen), BUS_LAT, 1, "R14");
        fetch(un, 1, 0, mem_word(un, gen), BUS_LAT, 1, "R11");

        repeat (3) @(negedge clk);
        chk("R4", "pending responses", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule